// File: doc/BRIEF.md
# Latched-Address Byte-Lane Static Memory

A single-port static memory of 18-bit words whose address, chip-select and write-data inputs reach the array through hold latches. One latch enable governs the address and chip-select latches and a second, independent one governs the write-data latch. While an enable is high its latch passes the input straight through. While it is low the latch keeps the value it last captured. Tying both enables high turns the block into a plain memory with no input latching.

The word is split into two 9-bit lanes, each with its own active-low write strobe, so either half can be written alone. An active-low output enable gates read data. The bidirectional data pins are modelled as separate `din`, `dout` and `dq_oe` signals. `dq_oe` is high only for an enabled read, and `dout` is meaningful only while `dq_oe` is high.

The latches are modelled on a clock. On each rising edge a latch whose enable is high stores its input. The value the block acts on is the live input while the enable is high and the stored value while it is low. Writes commit on the rising edge. `dq_oe` and `dout` are registered and change one edge after the inputs that cause them. `ADDR_W` sets the depth. A value of 16 gives the full 65,536 words, and the default is smaller to keep elaboration light.

Top module: `latched_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 18 bits, addressed by `addr` (ADDR_W = 16 gives 65,536 words).
- R2: While `addr_le` is high, the current `addr` and `ce_n` are used and are stored at each rising edge. While `addr_le` is low, the last stored address and chip select are used and the live `addr`/`ce_n` have no effect.
- R3: While `data_le` is high, the current `din` is the write data and is stored at each rising edge. While `data_le` is low, the last stored data is written and the live `din` has no effect.
- R4: With `addr_le` and `data_le` both held high, every access uses the live inputs, as in a memory with no input latches.
- R5: `we_lo_n` low writes bits 8:0 only, `we_hi_n` low writes bits 17:9 only, and both low write all 18 bits. The lane that is not written keeps its old value.
- R6: A write commits on a rising edge only when the effective chip select is low and at least one strobe is low.
- R7: With the effective chip select high, nothing is written and `dq_oe` is low after the edge, whatever the other inputs are.
- R8: After an edge with effective chip select low, both strobes high and `oe_n` low, `dq_oe` is high and `dout` holds the word at the effective address, including writes committed on earlier edges. With `oe_n` high, `dq_oe` is low.
- R9: After any edge at which either write strobe is low, `dq_oe` is low.
- R10: Synchronous reset (`rst` high) drives `dq_oe` low, clears the stored address and data, and leaves the stored chip select deasserted (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low, latched with the address |
| addr_le | input | 1 | Address/chip-select latch enable (high = pass through) |
| data_le | input | 1 | Write-data latch enable (high = pass through) |
| we_lo_n | input | 1 | Write strobe for bits 8:0, active low |
| we_hi_n | input | 1 | Write strobe for bits 17:9, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Write data |
| dout | output | 18 | Read data, meaningful only while dq_oe is high |
| dq_oe | output | 1 | Output driver enable |

## Verification
The array is first filled through the pass-through path with an address-dependent pattern, so a wrong address or a stale lane shows up as a wrong word on read-back. Single-lane writes with complementary patterns separate the two strobes and show whether the unwritten half is left untouched. Sequences that change `addr`, `ce_n` or `din` after a latch enable falls show whether the held values or the live ones are used. Deselected writes, reads with `oe_n` high and reads mixed with writes check every condition that must keep `dq_oe` low. A closing run of random traffic mixes all of these, with a behavioural reference model compared on every clock.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
endpackage

// File: rtl/input_latch.sv
// Hold latch in clocked form: stores on edges with le high; output
// follows the live input while le is high.
module input_latch #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)     held <= RST_VAL;
    else if (le) held <= d;
  end

  assign q = le ? d : held;
endmodule

// File: rtl/lane_ram.sv
// One write lane of the array, written so block RAM can be inferred.
module lane_ram #(
  parameter int ADDR_W = 10,
  parameter int W      = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/latched_sram.sv
module latched_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              addr_le,
  input  logic              data_le,
  input  logic              we_lo_n,
  input  logic              we_hi_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dq_oe
);
  localparam int AW1 = ADDR_W + 1;

  logic [ADDR_W:0]     sel_q;   // {chip select, address}
  logic [ADDR_W-1:0]   a_eff;
  logic                ce_eff;
  logic [WORD_W-1:0]   d_eff;
  logic [LANES-1:0]    we_n;
  logic                sel;

  // Address and chip select share one latch enable.
  input_latch #(.W(AW1), .RST_VAL({1'b1, {ADDR_W{1'b0}}})) u_alat (
    .clk(clk), .rst(rst), .le(addr_le), .d({ce_n, addr}), .q(sel_q)
  );

  input_latch #(.W(WORD_W), .RST_VAL('0)) u_dlat (
    .clk(clk), .rst(rst), .le(data_le), .d(din), .q(d_eff)
  );

  assign ce_eff = sel_q[ADDR_W];
  assign a_eff  = sel_q[ADDR_W-1:0];
  assign we_n   = {we_hi_n, we_lo_n};
  assign sel    = ~ce_eff;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_ram #(.ADDR_W(ADDR_W), .W(LANE_W)) u_ram (
      .clk  (clk),
      .we   (sel & ~we_n[l]),
      .addr (a_eff),
      .wdata(d_eff[l*LANE_W +: LANE_W]),
      .rdata(dout[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= sel & (&we_n) & ~oe_n;
  end
endmodule

// File: rtl/latched_sram_chk.sv
module latched_sram_chk (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic addr_le,
  input logic we_lo_n,
  input logic we_hi_n,
  input logic oe_n,
  input logic dq_oe
);
  p_reset_off_r10: assert property (@(posedge clk) rst |=> !dq_oe);

  p_write_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!we_lo_n || !we_hi_n) |=> !dq_oe);

  p_desel_off_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_le && ce_n) |=> !dq_oe);

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !dq_oe);

  p_read_on_r8: assert property (@(posedge clk) disable iff (rst)
    (addr_le && !ce_n && we_lo_n && we_hi_n && !oe_n) |=> dq_oe);
endmodule

bind latched_sram latched_sram_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .addr_le(addr_le),
  .we_lo_n(we_lo_n), .we_hi_n(we_hi_n), .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/latched_sram_tb.sv
module latched_sram_tb;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, addr_le = 1'b1, data_le = 1'b1;
  logic          we_lo_n = 1'b1, we_hi_n = 1'b1, oe_n = 1'b1;
  logic [17:0]   din = '0;
  logic [17:0]   dout;
  logic          dq_oe;

  latched_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .addr_le(addr_le),
    .data_le(data_le), .we_lo_n(we_lo_n), .we_hi_n(we_hi_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string tag = "R10";

  // Behavioural reference model
  logic [17:0]   model [DEPTH];
  logic [AW-1:0] m_a;
  logic          m_ce;
  logic [17:0]   m_d;
  logic          exp_oe;
  logic [17:0]   exp_dout;

  always @(posedge clk) begin : ref_model
    logic [AW-1:0] a;
    logic          c;
    logic [17:0]   d;
    if (rst) begin
      m_a = '0; m_ce = 1'b1; m_d = '0; exp_oe = 1'b0;
    end else begin
      a = addr_le ? addr : m_a;
      c = addr_le ? ce_n : m_ce;
      d = data_le ? din  : m_d;
      exp_oe   = !c && we_lo_n && we_hi_n && !oe_n;
      exp_dout = model[a];
      if (!c && !we_lo_n) model[a][8:0]  = d[8:0];
      if (!c && !we_hi_n) model[a][17:9] = d[17:9];
      if (addr_le) begin m_a = addr; m_ce = ce_n; end
      if (data_le) m_d = din;
    end
  end

  task automatic compare();
    checks++;
    if (dq_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: dq_oe=%b expected %b at t=%0t", tag, dq_oe, exp_oe, $time);
    end else if (exp_oe && dout !== exp_dout) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h at t=%0t", tag, dout, exp_dout, $time);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic c, input logic lo,
                      input logic hi, input logic o, input logic ale,
                      input logic dle, input logic [17:0] d);
    addr = a; ce_n = c; we_lo_n = lo; we_hi_n = hi; oe_n = o;
    addr_le = ale; data_le = dle; din = d;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [17:0] pat(input int i);
    return 18'(i * 18'h0B35 ^ 18'h2A5C3);
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    tag = "R10"; compare();                      // reset state
    rst = 1'b0;
    // R4/R1: fill every word with both latches transparent
    tag = "R4";
    for (int i = 0; i < DEPTH; i++) step(AW'(i), 0, 0, 0, 1, 1, 1, pat(i));
    tag = "R8";
    for (int i = 0; i < DEPTH; i += 37) step(AW'(i), 0, 1, 1, 0, 1, 1, 18'h0);
    step(AW'(DEPTH-1), 0, 1, 1, 0, 1, 1, 0);     // R1 top word
    step(AW'(DEPTH-1), 0, 1, 1, 0, 1, 1, 0);
    // R8: oe_n high keeps the driver off
    step(AW'(5), 0, 1, 1, 1, 1, 1, 0);
    step(AW'(5), 0, 1, 1, 1, 1, 1, 0);
    // R5: single-lane writes then read-back
    tag = "R5";
    step(AW'(12), 0, 0, 1, 1, 1, 1, 18'h3FFFF);
    step(AW'(12), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(12), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(13), 0, 1, 0, 1, 1, 1, 18'h00000);
    step(AW'(13), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(13), 0, 1, 1, 0, 1, 1, 0);
    // R6/R7: deselected write is dropped and output stays off
    tag = "R7";
    step(AW'(20), 1, 0, 0, 0, 1, 1, 18'h15555);
    step(AW'(20), 1, 1, 1, 0, 1, 1, 0);
    tag = "R6";
    step(AW'(20), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(20), 0, 1, 1, 0, 1, 1, 0);
    // R2: address held after latch enable drops
    tag = "R2";
    step(AW'(40), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(99), 1, 1, 1, 0, 0, 1, 0);
    step(AW'(7),  1, 1, 1, 0, 0, 1, 0);
    step(AW'(7),  1, 0, 0, 1, 0, 1, 18'h2ABCD);   // write to held address 40
    step(AW'(3),  0, 1, 1, 0, 1, 1, 0);
    step(AW'(40), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(40), 0, 1, 1, 0, 1, 1, 0);
    // R2/R7: held deselect ignores live chip select
    step(AW'(41), 1, 1, 1, 0, 1, 1, 0);
    step(AW'(41), 0, 1, 1, 0, 0, 1, 0);
    step(AW'(41), 0, 0, 0, 1, 0, 1, 18'h00111);
    step(AW'(41), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(41), 0, 1, 1, 0, 1, 1, 0);
    // R3: write data held after data latch enable drops
    tag = "R3";
    step(AW'(50), 0, 1, 1, 0, 1, 1, 18'h1F0F0);
    step(AW'(50), 0, 0, 0, 1, 1, 0, 18'h00F0F);
    step(AW'(50), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(50), 0, 1, 1, 0, 1, 1, 0);
    // R9: a strobe low turns the driver off
    tag = "R9";
    step(AW'(60), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(60), 0, 1, 0, 0, 1, 1, 18'h12345);
    step(AW'(60), 0, 1, 1, 0, 1, 1, 0);
    step(AW'(60), 0, 0, 1, 0, 1, 1, 18'h2FEDC);
    step(AW'(60), 0, 1, 1, 0, 1, 1, 0);
    // Mixed random traffic over all requirements
    tag = "R2/R3/R5/R8 random";
    for (int n = 0; n < 3000; n++)
      step(AW'($urandom_range(0, 15)), ($urandom_range(0, 7) == 0),
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           ($urandom_range(0, 5) == 0), $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0, 18'($urandom));
    // R10: reset mid-run turns the driver off
    tag = "R10";
    step(AW'(1), 0, 1, 1, 0, 1, 1, 0);
    rst = 1'b1;
    @(negedge clk);
    compare();
    rst = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule